// File: doc/BRIEF.md
# Oversampled Tag Response Frame Encoder

This block turns a stream of bytes into the serial chip sequence that a contactless tag returns to a reader. Every logical bit is stretched to a fixed number of identical chips, four by default. The encoder builds the whole frame by itself. It sends a long run of ones so the reader can lock its phase. It then sends a start-of-frame marker of a long low stretch followed by a short high stretch. Each byte goes out framed by a zero start bit and a one stop bit. The frame closes with an end-of-frame marker that uses the same pattern as the start marker. Any checksum bytes must already be in the incoming byte stream.

Bytes arrive over a valid/ready interface with a last flag. The sender may hold `in_valid` high at any time, and the encoder takes a byte only when it reaches a byte boundary. Back-pressure is total: while `in_ready` is low, nothing is consumed. If a byte is late at a boundary, the line idles high, one chip per strobe, until the byte arrives. Chips move only on the `chip_en` strobe, so the chip rate is set by whatever drives that strobe. `busy` marks the span of a frame.

Top module: `tag_frame_encoder`

## Requirements
- R1: After reset, `chip_out` is 1, `busy` is 0 and `in_ready` is 0.
- R2: `chip_out` changes only at a clock edge where `chip_en` is 1. Each logical bit is emitted as 4 consecutive identical chips, one per strobe.
- R3: In the idle state, the first `chip_en` strobe that finds `in_valid` high emits the first chip of the preamble, and `busy` rises at that same edge. The preamble is 20 logical ones, which is 80 one chips.
- R4: The start-of-frame marker follows the preamble directly: 10 logical zeros (40 chips), then 2 logical ones (8 chips).
- R5: `in_ready` is high only at a byte boundary: after the start-of-frame marker, or after a stop bit of a byte accepted with `in_last` = 0. A byte is taken on any clock edge where `in_valid` and `in_ready` are both 1. While `in_ready` is 0, nothing on the byte input is consumed.
- R6: An accepted byte is sent as one zero start bit, then the 8 data bits with bit 0 first, then one one stop bit. When the handshake and a strobe coincide, the start bit's first chip is emitted at that same edge.
- R7: While `in_ready` is high and no byte is offered, each strobe emits a one chip and `busy` stays 1.
- R8: The stop bit of a byte accepted with `in_last` = 1 is followed directly by the end-of-frame marker: 40 zero chips, then 8 one chips. `in_ready` stays 0 throughout.
- R9: `busy` falls at the edge that emits the final end-of-frame chip. While idle, `chip_out` stays 1 and `in_ready` stays 0 until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip strobe; one chip is emitted per strobe |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value, bit 0 sent first |
| in_last | input | 1 | Offered byte is the final one of the frame |
| in_ready | output | 1 | Encoder is at a byte boundary and takes the offered byte |
| chip_out | output | 1 | Serial chip output, 1 when idle |
| busy | output | 1 | A frame is on the line |

## Verification
Each chip is registered at the edge of its own strobe, so the bench raises `chip_en` for one cycle and compares `chip_out` and `busy` at the falling edge just after it against a chip list built arithmetically from the byte values. `in_ready` changes at the edge that closes the start-of-frame marker or a stop bit. The bench therefore samples it before each rising edge to decide whether a handshake happens at that edge. It then moves to the next byte only after that edge. Between strobes, `chip_out` is checked one falling edge before the next strobe to confirm it held.

// File: rtl/tag_frame_enc_pkg.sv
package tag_frame_enc_pkg;
  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_PRE,
    SEG_SOF_LO,
    SEG_SOF_HI,
    SEG_WAIT,
    SEG_START,
    SEG_DATA,
    SEG_STOP,
    SEG_EOF_LO,
    SEG_EOF_HI
  } seg_t;
endpackage

// File: rtl/tfe_chip_pacer.sv
module tfe_chip_pacer #(
  parameter int CHIPS = 4,
  parameter int BITW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [BITW-1:0] seg_bits,
  output logic            bit_end,
  output logic            seg_end
);
  localparam int CW = (CHIPS > 1) ? $clog2(CHIPS) : 1;

  logic [CW-1:0]   chip_cnt;
  logic [BITW-1:0] bit_cnt;

  assign bit_end = (chip_cnt == CW'(CHIPS - 1));
  assign seg_end = bit_end && (bit_cnt == seg_bits - BITW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_cnt <= '0;
      bit_cnt  <= '0;
    end else if (step) begin
      if (seg_end) begin
        chip_cnt <= '0;
        bit_cnt  <= '0;
      end else if (bit_end) begin
        chip_cnt <= '0;
        bit_cnt  <= bit_cnt + BITW'(1);
      end else begin
        chip_cnt <= chip_cnt + CW'(1);
      end
    end
  end

  // R2
  chip_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_cnt <= CW'(CHIPS - 1));
endmodule

// File: rtl/tfe_byte_shifter.sv
module tfe_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              shift,
  output logic              cur_bit,
  output logic              is_last
);
  logic [DATA_W-1:0] shreg;

  assign cur_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      is_last <= 1'b0;
    end else if (load) begin
      shreg   <= load_data;
      is_last <= load_last;
    end else if (shift) begin
      shreg <= shreg >> 1;
    end
  end

  // R6
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/tfe_frame_seq.sv
module tfe_frame_seq
  import tag_frame_enc_pkg::*;
#(
  parameter int PRE_BITS = 20,
  parameter int MARK_LO  = 10,
  parameter int MARK_HI  = 2,
  parameter int DATA_W   = 8,
  parameter int BITW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            in_valid,
  input  logic            byte_bit,
  input  logic            byte_last,
  input  logic            bit_end,
  input  logic            seg_end,
  output logic [BITW-1:0] seg_bits,
  output logic            step,
  output logic            load,
  output logic            shift,
  output logic            in_ready,
  output logic            chip_out,
  output logic            busy
);
  seg_t state, eff, nxt;
  logic cur;

  always_comb begin
    eff = state;
    if (state == SEG_IDLE && in_valid && chip_en) eff = SEG_PRE;
    if (state == SEG_WAIT && in_valid)            eff = SEG_START;
  end

  assign in_ready = (state == SEG_WAIT);
  assign load     = in_ready && in_valid;
  assign step     = chip_en && (eff != SEG_IDLE) && (eff != SEG_WAIT);
  assign shift    = step && (eff == SEG_DATA) && bit_end;
  assign busy     = (state != SEG_IDLE);

  always_comb begin
    case (eff)
      SEG_PRE:                seg_bits = BITW'(PRE_BITS);
      SEG_SOF_LO, SEG_EOF_LO: seg_bits = BITW'(MARK_LO);
      SEG_SOF_HI, SEG_EOF_HI: seg_bits = BITW'(MARK_HI);
      SEG_DATA:               seg_bits = BITW'(DATA_W);
      default:                seg_bits = BITW'(1);
    endcase
  end

  always_comb begin
    case (eff)
      SEG_SOF_LO, SEG_START, SEG_EOF_LO: cur = 1'b0;
      SEG_DATA:                          cur = byte_bit;
      default:                           cur = 1'b1;
    endcase
  end

  always_comb begin
    nxt = eff;
    if (step && seg_end) begin
      case (eff)
        SEG_PRE:    nxt = SEG_SOF_LO;
        SEG_SOF_LO: nxt = SEG_SOF_HI;
        SEG_SOF_HI: nxt = SEG_WAIT;
        SEG_START:  nxt = SEG_DATA;
        SEG_DATA:   nxt = SEG_STOP;
        SEG_STOP:   nxt = byte_last ? SEG_EOF_LO : SEG_WAIT;
        SEG_EOF_LO: nxt = SEG_EOF_HI;
        default:    nxt = SEG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEG_IDLE;
      chip_out <= 1'b1;
    end else begin
      state <= nxt;
      if (chip_en) chip_out <= step ? cur : 1'b1;
    end
  end

  // R2
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(chip_out));
  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> chip_out);
  // R5
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  // R6
  start_chip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && chip_en) |=> !chip_out);
endmodule

// File: rtl/tag_frame_encoder.sv
module tag_frame_encoder #(
  parameter int CHIPS    = 4,
  parameter int PRE_BITS = 20,
  parameter int MARK_LO  = 10,
  parameter int MARK_HI  = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              chip_out,
  output logic              busy
);
  localparam int MAXB01 = (PRE_BITS > MARK_LO) ? PRE_BITS : MARK_LO;
  localparam int MAXB23 = (DATA_W > MARK_HI) ? DATA_W : MARK_HI;
  localparam int MAXB   = (MAXB01 > MAXB23) ? MAXB01 : MAXB23;
  localparam int BITW   = $clog2(MAXB + 1);

  logic [BITW-1:0] seg_bits;
  logic step, load, shift, bit_end, seg_end, byte_bit, byte_last;

  tfe_chip_pacer #(.CHIPS(CHIPS), .BITW(BITW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .step(step), .seg_bits(seg_bits),
    .bit_end(bit_end), .seg_end(seg_end)
  );

  tfe_byte_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(in_data),
    .load_last(in_last), .shift(shift), .cur_bit(byte_bit), .is_last(byte_last)
  );

  tfe_frame_seq #(
    .PRE_BITS(PRE_BITS), .MARK_LO(MARK_LO), .MARK_HI(MARK_HI),
    .DATA_W(DATA_W), .BITW(BITW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .in_valid(in_valid),
    .byte_bit(byte_bit), .byte_last(byte_last), .bit_end(bit_end),
    .seg_end(seg_end), .seg_bits(seg_bits), .step(step), .load(load),
    .shift(shift), .in_ready(in_ready), .chip_out(chip_out), .busy(busy)
  );
endmodule

// File: tb/tag_frame_encoder_bench.sv
module tag_frame_encoder_bench;
  localparam int CPB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, chip_out, busy;

  always #5 clk = ~clk;

  tag_frame_encoder u_tag_frame_encoder (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .chip_out(chip_out), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       exp_q [0:4095];
  int         exp_n;
  int         eof_at;
  logic [7:0] bytes [0:7];
  int         nbytes, bi, gap_byte, gap_left;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic push_chip(input logic b);
    exp_q[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_bit(input logic b);
    for (int c = 0; c < CPB; c++) push_chip(b);
  endtask

  task automatic build(input int gap_len);
    exp_n = 0;
    for (int i = 0; i < 20; i++) push_bit(1'b1);
    for (int i = 0; i < 10; i++) push_bit(1'b0);
    for (int i = 0; i < 2; i++)  push_bit(1'b1);
    for (int b = 0; b < nbytes; b++) begin
      if (b == gap_byte) for (int g = 0; g < gap_len; g++) push_chip(1'b1);
      push_bit(1'b0);
      for (int j = 0; j < 8; j++) push_bit(bytes[b][j]);
      push_bit(1'b1);
    end
    eof_at = exp_n;
    for (int i = 0; i < 10; i++) push_bit(1'b0);
    for (int i = 0; i < 2; i++)  push_bit(1'b1);
  endtask

  task automatic tick(input logic en);
    logic hs;
    if (bi == gap_byte && gap_left > 0) in_valid = 1'b0;
    else in_valid = (bi < nbytes);
    if (bi < nbytes) begin
      in_data = bytes[bi];
      in_last = (bi == nbytes - 1);
    end
    hs = in_valid && in_ready;
    if (en && in_ready && !in_valid && gap_left > 0) gap_left--;
    chip_en = en;
    @(posedge clk);
    @(negedge clk);
    chip_en = 1'b0;
    if (hs) bi++;
  endtask

  task automatic run_frame(input int n, input int period, input int gb, input int gap_len);
    logic prev;
    nbytes = n;
    gap_byte = gb;
    gap_left = gap_len;
    bi = 0;
    build(gap_len);
    prev = chip_out;
    for (int k = 0; k < exp_n; k++) begin
      for (int p = 1; p < period; p++) tick(1'b0);
      if (period > 1) check(chip_out == prev, "R2 hold between strobes", chip_out, prev);
      tick(1'b1);
      if (k < 80)
        check(chip_out == exp_q[k], "R3 preamble chip", chip_out, exp_q[k]);
      else if (k < 128)
        check(chip_out == exp_q[k], "R4 start marker chip", chip_out, exp_q[k]);
      else if (k < eof_at)
        check(chip_out == exp_q[k], "R6 byte chip", chip_out, exp_q[k]);
      else
        check(chip_out == exp_q[k], "R8 end marker chip", chip_out, exp_q[k]);
      if (k == 0) check(busy == 1'b1, "R3 busy rises with first chip", busy, 1);
      if (k >= eof_at) check(in_ready == 1'b0, "R8 no ready during end marker", in_ready, 0);
      if (k == exp_n - 1) check(busy == 1'b0, "R9 busy falls with last chip", busy, 0);
      else check(busy == 1'b1, "R7 busy within frame", busy, 1);
      prev = chip_out;
    end
    check(bi == n, "R5 bytes consumed", bi, n);
    nbytes = 0;
    for (int i = 0; i < 3; i++) begin
      tick(1'b1);
      check(chip_out == 1'b1 && busy == 1'b0 && in_ready == 1'b0,
            "R9 idle line high", {chip_out, busy, in_ready}, 3'b100);
    end
  endtask

  initial begin
    nbytes = 0;
    bi = 0;
    gap_byte = -1;
    gap_left = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(chip_out == 1'b1, "R1 reset chip_out", chip_out, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);

    bytes[0] = 8'hA5;
    run_frame(1, 1, -1, 0);

    bytes[0] = 8'h00; bytes[1] = 8'hFF; bytes[2] = 8'h3C;
    run_frame(3, 3, -1, 0);

    // R7 late byte: line idles high for the gap
    bytes[0] = 8'h81; bytes[1] = 8'h7E;
    run_frame(2, 2, 1, 5);

    bytes[0] = 8'h5A; bytes[1] = 8'hC3; bytes[2] = 8'h01; bytes[3] = 8'h80;
    run_frame(4, 1, 2, 3);

    // exhaustive single-byte sweep
    for (int v = 0; v < 256; v++) begin
      bytes[0] = 8'(v);
      run_frame(1, 1, -1, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule